// File: doc/BRIEF.md
# Crosslink Hot-Reset and Link-Disable State Controller

This block is a simplified link-state controller for one switch port whose link partner is another switch port, so the two ends form a crosslink. It decides when the port brings its link up and when it enters the hot-reset or disabled state. The inputs are the switch-port role of the port, the lane role it negotiated during training, decoded hot-reset and disable flags from received training sets, and higher-layer hot-reset and link-disable requests. A port-off control and a legacy-compatibility enable complete the inputs. The compatibility enable only takes effect when a full-retrain strobe arrives.

The controller has six named states: DETECT, POLL_CFG, L0, RECOVERY, HOT_RESET and DISABLED. The named transitions are: bring-up (DETECT to POLL_CFG, then POLL_CFG to L0); remote entry (L0 straight to HOT_RESET or DISABLED on a received flag); local entry (L0 to RECOVERY for a fixed number of cycles, then to the requested target); hold exit (HOT_RESET or DISABLED to DETECT); and forced return (any state to DETECT on port-off or full retrain). During a local entry, the controller drives the matching flag into the outgoing training sets. While compatibility is latched, it masks the newer bits of symbol 4 of outgoing TS1 and TS2 sets. On a hot reset of an upstream switch port it raises a partition-wide reset indication. A hot reset of a downstream switch port stays local and does not touch configuration state.

Top module: `xlink_lctl`

## Requirements
- R1: After reset the state is DETECT, both transmit flags and the partition-reset output are 0, and the symbol-4 mask is 8'hFF.
- R2: State codes on `state_o` are DETECT=0, POLL_CFG=1, L0=2, RECOVERY=3, HOT_RESET=4, DISABLED=5. DETECT moves to POLL_CFG on the clock after `rx_present_i` is high. POLL_CFG moves to L0 on the clock after `cfg_done_i` is high.
- R3: In L0, a received disable flag moves the state to DISABLED on the next clock. Otherwise a received hot-reset flag moves it to HOT_RESET on the next clock. This holds for both switch-port roles and both lane roles, and the disable flag wins when both flags are high.
- R4: A higher-layer hot-reset request in L0 is honoured only when `dsp_role_i`=1 and `dn_lanes_i`=1. The controller then spends exactly REC_CYC cycles in RECOVERY before entering HOT_RESET. In every other role combination the request is ignored and the state stays L0.
- R5: A higher-layer link-disable request in L0 is honoured whenever `dsp_role_i`=1, whatever the lane role. The controller spends REC_CYC cycles in RECOVERY and then enters DISABLED. With `dsp_role_i`=0 the request is ignored.
- R6: `tx_hot_o` (or `tx_dis_o`) is high during RECOVERY and the following HOT_RESET (or DISABLED) only when that state was reached through a local request. Both flags are 0 in every other case, including remote entry.
- R7: `part_rst_o` is high in HOT_RESET when `dsp_role_i`=0 and is never high when `dsp_role_i`=1.
- R8: HOT_RESET and DISABLED are left for DETECT after HOLD_CYC cycles, counted from entry, once the received flag and the qualified request that cause the state are both low. While either of them stays high, the state is held.
- R9: `port_off_i` sends the controller to DETECT on the next clock from any state, and holds it there while high. It takes priority over every other input.
- R10: `full_retrain_i` sends the controller to DETECT on the next clock and latches `compat_en_i`. While the latch is set the mask is 8'h3B (bits 2, 6 and 7 cleared); otherwise it is 8'hFF. A change on `compat_en_i` without the strobe leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsp_role_i | input | 1 | 1 = downstream switch port, 0 = upstream switch port |
| dn_lanes_i | input | 1 | 1 = lanes trained as downstream lanes, 0 = upstream lanes |
| rx_present_i | input | 1 | Link partner detected |
| cfg_done_i | input | 1 | Link configuration finished |
| rx_hot_i | input | 1 | Received training sets carry the hot-reset flag |
| rx_dis_i | input | 1 | Received training sets carry the disable flag |
| hl_hot_req_i | input | 1 | Higher-layer hot-reset request |
| hl_dis_req_i | input | 1 | Higher-layer link-disable request |
| port_off_i | input | 1 | Port placed in its disabled operating mode |
| compat_en_i | input | 1 | Legacy-compatibility enable, sampled on full retrain |
| full_retrain_i | input | 1 | Full-retrain strobe |
| state_o | output | 3 | Current link state code |
| tx_hot_o | output | 1 | Hot-reset flag for transmitted training sets |
| tx_dis_o | output | 1 | Disable flag for transmitted training sets |
| sym4_mask_o | output | 8 | AND mask for symbol 4 of outgoing TS1/TS2 |
| part_rst_o | output | 1 | Partition-wide reset indication |

## Verification
The assertions check on every cycle that port-off forces DETECT, that a RECOVERY stay never exceeds REC_CYC cycles, and that an upstream switch port never enters RECOVERY. They also check that the transmit flags are mutually exclusive and appear only in RECOVERY or a target state, that a held hot-reset flag keeps HOT_RESET, and that the mask only moves after a full retrain. Only the bench scenarios can show the exact RECOVERY length, which role and lane combinations honour or ignore each request, the reset-scope output in each role, the timing of the hold exit, and the latch-on-retrain behaviour of the compatibility mask.

// File: rtl/xlink_pkg.sv
package xlink_pkg;

    typedef enum logic [2:0] {
        LS_DETECT   = 3'd0,
        LS_POLLCFG  = 3'd1,
        LS_L0       = 3'd2,
        LS_RECOV    = 3'd3,
        LS_HOTRST   = 3'd4,
        LS_DISABLED = 3'd5
    } lstate_e;

    typedef enum logic [1:0] {
        TG_NONE = 2'd0,
        TG_HOT  = 2'd1,
        TG_DIS  = 2'd2
    } target_e;

    localparam int SYM_W = 8;

endpackage

// File: rtl/xlink_req_qual.sv
module xlink_req_qual (
    input  logic dsp_role_i,
    input  logic dn_lanes_i,
    input  logic hl_hot_req_i,
    input  logic hl_dis_req_i,
    output logic q_hot_o,
    output logic q_dis_o
);

    // Hot reset from a higher layer needs a downstream switch port that
    // trained with downstream lanes; disable needs only the downstream role.
    always_comb begin
        q_hot_o = 1'b0;
        q_dis_o = 1'b0;
        if (dsp_role_i) begin
            q_dis_o = hl_dis_req_i;
            if (dn_lanes_i) begin
                q_hot_o = hl_hot_req_i;
            end
        end
    end

endmodule

// File: rtl/xlink_fsm.sv
module xlink_fsm
    import xlink_pkg::*;
#(
    parameter int REC_CYC  = 4,
    parameter int HOLD_CYC = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rx_present_i,
    input  logic    cfg_done_i,
    input  logic    rx_hot_i,
    input  logic    rx_dis_i,
    input  logic    q_hot_i,
    input  logic    q_dis_i,
    input  logic    port_off_i,
    input  logic    full_retrain_i,
    output lstate_e state_o,
    output target_e tgt_o
);

    localparam int TMAX = (REC_CYC > HOLD_CYC) ? REC_CYC : HOLD_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] REC_LAST  = TW'(REC_CYC - 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] TSAT      = TW'(TMAX);

    lstate_e        st_q, st_d;
    target_e        tg_q, tg_d;
    logic [TW-1:0]  tmr_q;
    logic           hot_cause, dis_cause;

    assign hot_cause = rx_hot_i | q_hot_i;
    assign dis_cause = rx_dis_i | q_dis_i;

    // Next-state selection
    always_comb begin
        st_d = st_q;
        tg_d = tg_q;
        if (port_off_i || full_retrain_i) begin
            st_d = LS_DETECT;
            tg_d = TG_NONE;
        end else begin
            unique case (st_q)
                LS_DETECT: begin
                    tg_d = TG_NONE;
                    if (rx_present_i) st_d = LS_POLLCFG;
                end
                LS_POLLCFG: begin
                    if (cfg_done_i) st_d = LS_L0;
                end
                LS_L0: begin
                    if (rx_dis_i) begin
                        st_d = LS_DISABLED;
                        tg_d = TG_NONE;
                    end else if (rx_hot_i) begin
                        st_d = LS_HOTRST;
                        tg_d = TG_NONE;
                    end else if (q_dis_i) begin
                        st_d = LS_RECOV;
                        tg_d = TG_DIS;
                    end else if (q_hot_i) begin
                        st_d = LS_RECOV;
                        tg_d = TG_HOT;
                    end
                end
                LS_RECOV: begin
                    if (tmr_q >= REC_LAST) begin
                        st_d = (tg_q == TG_DIS) ? LS_DISABLED : LS_HOTRST;
                    end
                end
                LS_HOTRST: begin
                    if ((tmr_q >= HOLD_LAST) && !hot_cause) begin
                        st_d = LS_DETECT;
                        tg_d = TG_NONE;
                    end
                end
                LS_DISABLED: begin
                    if ((tmr_q >= HOLD_LAST) && !dis_cause) begin
                        st_d = LS_DETECT;
                        tg_d = TG_NONE;
                    end
                end
                default: begin
                    st_d = LS_DETECT;
                    tg_d = TG_NONE;
                end
            endcase
        end
    end

    // State register and dwell timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LS_DETECT;
            tg_q  <= TG_NONE;
            tmr_q <= '0;
        end else begin
            st_q <= st_d;
            tg_q <= tg_d;
            if (st_d != st_q) begin
                tmr_q <= '0;
            end else if (tmr_q != TSAT) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign state_o = st_q;
    assign tgt_o   = tg_q;

endmodule

// File: rtl/xlink_ts_ctl.sv
module xlink_ts_ctl
    import xlink_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lstate_e          state_i,
    input  target_e          tgt_i,
    input  logic             dsp_role_i,
    input  logic             compat_en_i,
    input  logic             full_retrain_i,
    output logic             tx_hot_o,
    output logic             tx_dis_o,
    output logic [SYM_W-1:0] sym4_mask_o,
    output logic             part_rst_o
);

    localparam logic [SYM_W-1:0] MASK_ALL    = '1;
    localparam logic [SYM_W-1:0] MASK_COMPAT = MASK_ALL & ~SYM_W'(8'hC4);

    logic compat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            compat_q <= 1'b0;
        end else if (full_retrain_i) begin
            compat_q <= compat_en_i;
        end
    end

    // Output decode
    always_comb begin
        tx_hot_o    = 1'b0;
        tx_dis_o    = 1'b0;
        part_rst_o  = 1'b0;
        sym4_mask_o = compat_q ? MASK_COMPAT : MASK_ALL;
        unique case (state_i)
            LS_RECOV: begin
                tx_hot_o = (tgt_i == TG_HOT);
                tx_dis_o = (tgt_i == TG_DIS);
            end
            LS_HOTRST: begin
                tx_hot_o   = (tgt_i == TG_HOT);
                part_rst_o = !dsp_role_i;
            end
            LS_DISABLED: begin
                tx_dis_o = (tgt_i == TG_DIS);
            end
            default: begin
                tx_hot_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xlink_lctl.sv
module xlink_lctl
    import xlink_pkg::*;
#(
    parameter int REC_CYC  = 4,
    parameter int HOLD_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dsp_role_i,
    input  logic             dn_lanes_i,
    input  logic             rx_present_i,
    input  logic             cfg_done_i,
    input  logic             rx_hot_i,
    input  logic             rx_dis_i,
    input  logic             hl_hot_req_i,
    input  logic             hl_dis_req_i,
    input  logic             port_off_i,
    input  logic             compat_en_i,
    input  logic             full_retrain_i,
    output logic [2:0]       state_o,
    output logic             tx_hot_o,
    output logic             tx_dis_o,
    output logic [SYM_W-1:0] sym4_mask_o,
    output logic             part_rst_o
);

    logic    q_hot, q_dis;
    lstate_e st;
    target_e tg;

    xlink_req_qual u_qual (
        .dsp_role_i   (dsp_role_i),
        .dn_lanes_i   (dn_lanes_i),
        .hl_hot_req_i (hl_hot_req_i),
        .hl_dis_req_i (hl_dis_req_i),
        .q_hot_o      (q_hot),
        .q_dis_o      (q_dis)
    );

    xlink_fsm #(
        .REC_CYC  (REC_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_present_i   (rx_present_i),
        .cfg_done_i     (cfg_done_i),
        .rx_hot_i       (rx_hot_i),
        .rx_dis_i       (rx_dis_i),
        .q_hot_i        (q_hot),
        .q_dis_i        (q_dis),
        .port_off_i     (port_off_i),
        .full_retrain_i (full_retrain_i),
        .state_o        (st),
        .tgt_o          (tg)
    );

    xlink_ts_ctl u_ts (
        .clk            (clk),
        .rst_n          (rst_n),
        .state_i        (st),
        .tgt_i          (tg),
        .dsp_role_i     (dsp_role_i),
        .compat_en_i    (compat_en_i),
        .full_retrain_i (full_retrain_i),
        .tx_hot_o       (tx_hot_o),
        .tx_dis_o       (tx_dis_o),
        .sym4_mask_o    (sym4_mask_o),
        .part_rst_o     (part_rst_o)
    );

    assign state_o = st;

endmodule

// File: rtl/xlink_lctl_chk.sv
module xlink_lctl_chk
    import xlink_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsp_role_i,
    input logic             rx_hot_i,
    input logic             port_off_i,
    input logic             full_retrain_i,
    input logic [2:0]       state_o,
    input logic             tx_hot_o,
    input logic             tx_dis_o,
    input logic [SYM_W-1:0] sym4_mask_o
);

    localparam int RW = $clog2(REC_CYC + 2);

    logic [RW-1:0] rec_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_run <= '0;
        end else if (state_o == 3'(LS_RECOV)) begin
            if (rec_run != RW'(REC_CYC + 1)) rec_run <= rec_run + 1'b1;
        end else begin
            rec_run <= '0;
        end
    end

    p_off_detect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_off_i |=> (state_o == 3'(LS_DETECT)));

    p_rec_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_run <= RW'(REC_CYC));

    p_usp_no_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_role_i && state_o == 3'(LS_L0)) |=> (state_o != 3'(LS_RECOV)));

    p_tx_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_hot_o, tx_dis_o}));

    p_tx_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hot_o || tx_dis_o) |-> (state_o >= 3'(LS_RECOV)));

    p_hot_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(LS_HOTRST) && rx_hot_i && !port_off_i && !full_retrain_i)
        |=> (state_o == 3'(LS_HOTRST)));

    p_mask_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(full_retrain_i) |-> $stable(sym4_mask_o));

endmodule

bind xlink_lctl xlink_lctl_chk #(.REC_CYC(REC_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dsp_role_i     (dsp_role_i),
    .rx_hot_i       (rx_hot_i),
    .port_off_i     (port_off_i),
    .full_retrain_i (full_retrain_i),
    .state_o        (state_o),
    .tx_hot_o       (tx_hot_o),
    .tx_dis_o       (tx_dis_o),
    .sym4_mask_o    (sym4_mask_o)
);

// File: tb/sim_xlink_lctl.sv
module sim_xlink_lctl;

    localparam int REC  = 4;
    localparam int HOLD = 5;

    localparam int S_DET = 0, S_POLL = 1, S_L0 = 2, S_REC = 3, S_HOT = 4, S_DIS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dsp_role_i = 1'b1, dn_lanes_i = 1'b1;
    logic       rx_present_i = 1'b0, cfg_done_i = 1'b0;
    logic       rx_hot_i = 1'b0, rx_dis_i = 1'b0;
    logic       hl_hot_req_i = 1'b0, hl_dis_req_i = 1'b0;
    logic       port_off_i = 1'b0, compat_en_i = 1'b0, full_retrain_i = 1'b0;
    logic [2:0] state_o;
    logic       tx_hot_o, tx_dis_o, part_rst_o;
    logic [7:0] sym4_mask_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xlink_lctl #(.REC_CYC(REC), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .dsp_role_i(dsp_role_i), .dn_lanes_i(dn_lanes_i),
        .rx_present_i(rx_present_i), .cfg_done_i(cfg_done_i),
        .rx_hot_i(rx_hot_i), .rx_dis_i(rx_dis_i),
        .hl_hot_req_i(hl_hot_req_i), .hl_dis_req_i(hl_dis_req_i),
        .port_off_i(port_off_i), .compat_en_i(compat_en_i),
        .full_retrain_i(full_retrain_i), .state_o(state_o),
        .tx_hot_o(tx_hot_o), .tx_dis_o(tx_dis_o),
        .sym4_mask_o(sym4_mask_o), .part_rst_o(part_rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_l0();
        rx_present_i = 1'b1;
        cfg_done_i   = 1'b1;
        chk("R2 start detect", int'(state_o), S_DET);
        tick();
        chk("R2 poll_cfg", int'(state_o), S_POLL);
        tick();
        chk("R2 l0", int'(state_o), S_L0);
    endtask

    task automatic force_detect();
        port_off_i = 1'b1;
        tick();
        port_off_i = 1'b0;
        chk("R9 off to detect", int'(state_o), S_DET);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 state", int'(state_o), S_DET);
        chk("R1 tx_hot", int'(tx_hot_o), 0);
        chk("R1 tx_dis", int'(tx_dis_o), 0);
        chk("R1 mask", int'(sym4_mask_o), 8'hFF);
        chk("R1 part_rst", int'(part_rst_o), 0);
        rst_n = 1'b1;
        tick();
        chk("R2 idle detect", int'(state_o), S_DET);

        // Sweep roles x lane roles x stimulus kinds (R3 R4 R5 R6 R7 R8)
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l < 2; l++) begin
                for (int k = 0; k < 4; k++) begin
                    bit direct, honored;
                    int tgt, exp_hot, exp_dis;
                    dsp_role_i = d[0];
                    dn_lanes_i = l[0];
                    go_l0();
                    direct  = (k < 2);
                    honored = direct || (k == 2 && d == 1 && l == 1) || (k == 3 && d == 1);
                    tgt     = (k == 0 || k == 2) ? S_HOT : S_DIS;
                    exp_hot = (!direct && tgt == S_HOT) ? 1 : 0;
                    exp_dis = (!direct && tgt == S_DIS) ? 1 : 0;
                    rx_hot_i     = (k == 0);
                    rx_dis_i     = (k == 1);
                    hl_hot_req_i = (k == 2);
                    hl_dis_req_i = (k == 3);
                    if (!honored) begin
                        for (int c = 0; c < REC + 1; c++) begin
                            tick();
                            chk("R4 R5 request ignored", int'(state_o), S_L0);
                            chk("R6 no tx flag", int'({tx_hot_o, tx_dis_o}), 0);
                        end
                        rx_hot_i = 0; rx_dis_i = 0; hl_hot_req_i = 0; hl_dis_req_i = 0;
                        force_detect();
                    end else begin
                        if (!direct) begin
                            for (int c = 0; c < REC; c++) begin
                                tick();
                                chk("R4 R5 recovery", int'(state_o), S_REC);
                                chk("R6 tx_hot in recovery", int'(tx_hot_o), exp_hot);
                                chk("R6 tx_dis in recovery", int'(tx_dis_o), exp_dis);
                            end
                        end
                        tick();
                        chk("R3 R4 R5 target", int'(state_o), tgt);
                        chk("R6 tx_hot target", int'(tx_hot_o), exp_hot);
                        chk("R6 tx_dis target", int'(tx_dis_o), exp_dis);
                        chk("R7 part_rst", int'(part_rst_o), (tgt == S_HOT && d == 0) ? 1 : 0);
                        rx_hot_i = 0; rx_dis_i = 0; hl_hot_req_i = 0; hl_dis_req_i = 0;
                        for (int c = 0; c < HOLD - 1; c++) begin
                            tick();
                            chk("R8 hold", int'(state_o), tgt);
                        end
                        tick();
                        chk("R8 exit", int'(state_o), S_DET);
                    end
                end
            end
        end

        // R3: disable wins when both flags arrive
        dsp_role_i = 1; dn_lanes_i = 1;
        go_l0();
        rx_hot_i = 1; rx_dis_i = 1;
        tick();
        chk("R3 disable priority", int'(state_o), S_DIS);
        rx_dis_i = 0;
        force_detect();

        // R8: held hot-reset flag keeps HOT_RESET past the hold count
        go_l0();
        tick();
        chk("R3 hot entry", int'(state_o), S_HOT);
        repeat (HOLD + 3) tick();
        chk("R8 held by flag", int'(state_o), S_HOT);
        rx_hot_i = 0;
        tick();
        chk("R8 release exit", int'(state_o), S_DET);

        // R9: port-off in the middle of recovery, held in DETECT
        go_l0();
        hl_dis_req_i = 1;
        tick();
        tick();
        chk("R5 recovery", int'(state_o), S_REC);
        port_off_i = 1;
        hl_dis_req_i = 0;
        for (int c = 0; c < 3; c++) begin
            tick();
            chk("R9 held detect", int'(state_o), S_DET);
        end
        port_off_i = 0;
        tick();
        chk("R9 release bring-up", int'(state_o), S_POLL);
        tick();

        // R10: compatibility latch
        compat_en_i = 1;
        tick();
        chk("R10 no effect without strobe", int'(sym4_mask_o), 8'hFF);
        full_retrain_i = 1;
        tick();
        full_retrain_i = 0;
        chk("R10 retrain to detect", int'(state_o), S_DET);
        chk("R10 mask compat", int'(sym4_mask_o), 8'h3B);
        compat_en_i = 0;
        tick();
        tick();
        chk("R10 mask kept", int'(sym4_mask_o), 8'h3B);
        full_retrain_i = 1;
        tick();
        full_retrain_i = 0;
        chk("R10 mask cleared", int'(sym4_mask_o), 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule